// File: doc/BRIEF.md
# Masked Latched Status Register Bank

This block holds the event and alarm status registers of a multi-channel line framer and exposes them on a byte-wide host bus. Each channel has six status registers: two main status registers (indices 0 and 1), three information registers (indices 2 to 4) and an HDLC/BOC status register (index 5). Every status bit latches when its input is high. It stays set until the host clears it, even after the input has gone away. Framing logic and HDLC internals sit outside the block. Their events arrive on `statIn`, as single-cycle pulses for events and as levels for alarms.

The host services a register in two writes. The first write carries a mask and refreshes only the selected bits of a readable copy. The host then reads the copy. A second write to the same register carries the read value ANDed with the mask, and only its one-bits are cleared in the latch. Alarms that are still present set again at once, and new events are never lost.

Three interrupt enable registers per channel gate the main status and HDLC bits onto an active-low interrupt. A shared summary register shows which channel is asking for service and whether the request comes from general status or from the HDLC controller.

Top module: `status_latch_bank`

## Requirements
- R1: After reset every latched bit, readable copy and interrupt enable register is zero, `intN` is high, and a read of any register returns 0.
- R2: A high input bit sets its latched bit at the next clock edge. The bit stays set after the input falls, until a clear write removes it.
- R3: The first write to a status register (a capture write) loads each readable-copy bit whose data bit is 1 with the current latched value. Readable-copy bits whose data bit is 0 keep their previous value. The latch is not changed.
- R4: The next write to the same register (a clear write) clears exactly the latched bits whose data bit is 1 and leaves the readable copy unchanged. Writes to a register alternate between capture and clear, starting with capture after reset.
- R5: An event bit that has been cleared stays zero until a new pulse arrives.
- R6: A level alarm that is still high sets its bit again at the clear edge, so the next capture shows it as one.
- R7: An input that is high in the same cycle as a clear of its bit wins, and the bit stays set.
- R8: `intN` is active low and is registered: it goes low one cycle after a bit becomes set under an enable. Bits of register 0 are enabled by the register at index 8, register 1 by index 9, and register 5 by index 10, with bit n of the enable gating bit n. Information registers 2 to 4 never drive the interrupt.
- R9: Index 15 reads the live summary from any channel. Bit 2c is set when channel c has an enabled bit in register 0 or 1. Bit 2c+1 is set when channel c has an enabled bit in register 5. NUM_CH is at most 4.
- R10: Indices 8 to 10 are read/write enable registers. Writes to index 15 or to unused indices (6, 7, 11 to 14) change nothing, and unused indices read 0.
- R11: `hostAddr` is {channel, 4-bit index}. Input bit (c*6+r)*8+n feeds bit n of register r of channel c, and the channels do not affect each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostWr | input | 1 | Write strobe, one cycle per write |
| hostAddr | input | CH_W+4 | {channel, register index} |
| hostWdata | input | 8 | Write data (mask or clear value) |
| hostRdata | output | 8 | Combinational read of the addressed register |
| statIn | input | NUM_CH*48 | Event pulses and alarm levels, one bit per status bit |
| intN | output | 1 | Active-low interrupt request |

## Verification
Capture masks are tried at full width, at one nibble and at zero. These show that selected copy bits are refreshed and unselected ones are held, rather than the whole copy being reloaded. Clear values are tried with one bit of a pair, with the full value, and with zero. Events are tried as lone pulses, as pulses in the same cycle as a clear, and as held levels, which separates set priority and alarm re-assertion from plain latching. Interrupt patterns cover enabled and disabled bits in main, information and HDLC registers across two channels. Each pattern is then read back through the summary register, so routing to the wrong channel or the wrong source is visible.

// File: rtl/statbank_pkg.sv
package statbank_pkg;
  localparam int DW          = 8;   // host data width
  localparam int REG_COUNT   = 6;   // status registers per channel
  localparam int IMR_COUNT   = 3;   // interrupt enable registers per channel
  localparam int REG_W       = 4;   // register index width
  localparam int CH_W_MAX    = 3;   // channel field carried in strobes
  localparam int IMR_BASE    = 8;   // first enable register index
  localparam int HDLC_IDX    = 5;   // HDLC/BOC status register index
  localparam logic [REG_W-1:0] SUMMARY_IDX = 4'hF;

  typedef struct packed {
    logic                capture;
    logic                clear;
    logic                imrWr;
    logic [CH_W_MAX-1:0] ch;
    logic [REG_W-1:0]    regIdx;
    logic [DW-1:0]       data;
  } strobe_t;
endpackage

// File: rtl/statbank_ctrl.sv
module statbank_ctrl
  import statbank_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CH_W   = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWr,
  input  logic [CH_W-1:0]   chIdx,
  input  logic [REG_W-1:0]  regIdx,
  input  logic [DW-1:0]     hostWdata,
  output strobe_t           strobe
);
  localparam int SLOTS = NUM_CH * REG_COUNT;

  logic [NUM_CH-1:0] chMatch;
  logic [SLOTS-1:0]  hitVec;
  logic [SLOTS-1:0]  armedVec;
  logic              statHit;
  logic              selArmed;
  logic              isImr;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign chMatch[c] = (chIdx == CH_W'(c));
    for (genvar r = 0; r < REG_COUNT; r++) begin : g_reg
      logic armed;
      assign hitVec[c*REG_COUNT+r] = hostWr && chMatch[c] && (regIdx == REG_W'(r));
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                       armed <= 1'b0;
        else if (hitVec[c*REG_COUNT+r])  armed <= ~armed;
      end
      assign armedVec[c*REG_COUNT+r] = armed;
    end
  end

  assign statHit  = |hitVec;
  assign selArmed = |(hitVec & armedVec);
  assign isImr    = (regIdx >= REG_W'(IMR_BASE)) && (regIdx < REG_W'(IMR_BASE + IMR_COUNT));

  always_comb begin
    strobe         = '0;
    strobe.capture = statHit && !selArmed;
    strobe.clear   = statHit && selArmed;
    strobe.imrWr   = hostWr && isImr && (|chMatch);
    strobe.ch      = CH_W_MAX'(chIdx);
    strobe.regIdx  = regIdx;
    strobe.data    = hostWdata;
  end

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.capture, strobe.clear, strobe.imrWr}));

  // R10
  strobe_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !hostWr |-> !(strobe.capture || strobe.clear || strobe.imrWr));

  // R4
  phase_alt_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> $past(armedVec) != armedVec);
endmodule

// File: rtl/statbank_cell.sv
module statbank_cell
  import statbank_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic [DW-1:0] setIn,
  input  logic          capture,
  input  logic          clear,
  input  logic [DW-1:0] data,
  output logic [DW-1:0] latOut,
  output logic [DW-1:0] copyOut
);
  logic [DW-1:0] clrMask;
  assign clrMask = clear ? data : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latOut  <= '0;
      copyOut <= '0;
    end else begin
      latOut <= setIn | (latOut & ~clrMask);
      if (capture) copyOut <= (data & latOut) | (~data & copyOut);
    end
  end

  // R2
  lat_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((latOut & $past(latOut & ~clrMask)) == $past(latOut & ~clrMask)));

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((latOut & $past(setIn)) == $past(setIn)));

  // R3
  copy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !capture |=> $stable(copyOut));

  // R3
  copy_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    capture |=> ((copyOut ^ $past(copyOut)) & ~$past(data)) == '0);
endmodule

// File: rtl/statbank_dp.sv
module statbank_dp
  import statbank_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CH_W   = 1
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  strobe_t                         strobe,
  input  logic [NUM_CH*REG_COUNT*DW-1:0]  statIn,
  input  logic [CH_W-1:0]                 rdCh,
  input  logic [REG_W-1:0]                rdReg,
  output logic [DW-1:0]                   rdData,
  output logic                            intN
);
  localparam int BANK_W = NUM_CH * REG_COUNT * DW;

  logic [BANK_W-1:0] latV;
  logic [BANK_W-1:0] copyV;
  logic [NUM_CH-1:0][IMR_COUNT-1:0][DW-1:0] imr;
  logic [NUM_CH-1:0] stReq;
  logic [NUM_CH-1:0] hdReq;
  logic [DW-1:0]     summary;
  logic              anyReq;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    for (genvar r = 0; r < REG_COUNT; r++) begin : g_reg
      logic sel;
      assign sel = (strobe.ch == CH_W_MAX'(c)) && (strobe.regIdx == REG_W'(r));
      statbank_cell u_cell (
        .clk     (clk),
        .rstN    (rstN),
        .setIn   (statIn[(c*REG_COUNT+r)*DW +: DW]),
        .capture (strobe.capture && sel),
        .clear   (strobe.clear && sel),
        .data    (strobe.data),
        .latOut  (latV[(c*REG_COUNT+r)*DW +: DW]),
        .copyOut (copyV[(c*REG_COUNT+r)*DW +: DW])
      );
    end
    assign stReq[c] = |((latV[(c*REG_COUNT+0)*DW +: DW] & imr[c][0]) |
                        (latV[(c*REG_COUNT+1)*DW +: DW] & imr[c][1]));
    assign hdReq[c] = |(latV[(c*REG_COUNT+HDLC_IDX)*DW +: DW] & imr[c][2]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      imr <= '0;
    end else if (strobe.imrWr) begin
      for (int c = 0; c < NUM_CH; c++)
        for (int k = 0; k < IMR_COUNT; k++)
          if (strobe.ch == CH_W_MAX'(c) && strobe.regIdx == REG_W'(IMR_BASE + k))
            imr[c][k] <= strobe.data;
    end
  end

  always_comb begin
    summary = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      summary[2*c]   = stReq[c];
      summary[2*c+1] = hdReq[c];
    end
  end

  assign anyReq = |summary;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) intN <= 1'b1;
    else       intN <= ~anyReq;
  end

  always_comb begin
    rdData = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      for (int r = 0; r < REG_COUNT; r++)
        if (rdCh == CH_W'(c) && rdReg == REG_W'(r))
          rdData = copyV[(c*REG_COUNT+r)*DW +: DW];
      for (int k = 0; k < IMR_COUNT; k++)
        if (rdCh == CH_W'(c) && rdReg == REG_W'(IMR_BASE + k))
          rdData = imr[c][k];
    end
    if (rdReg == SUMMARY_IDX) rdData = summary;
  end

  // R10
  imr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.imrWr |=> $stable(imr));

  // R8
  int_assert_chk: assert property (@(posedge clk) disable iff (!rstN)
    anyReq |=> !intN);

  // R8
  int_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    !anyReq |=> intN);
endmodule

// File: rtl/status_latch_bank.sv
module status_latch_bank
  import statbank_pkg::*;
#(
  parameter  int NUM_CH = 2,  // 1 to 4 (summary holds two bits per channel)
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W = CH_W + REG_W,
  localparam int IN_W   = NUM_CH * REG_COUNT * DW
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWr,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DW-1:0]     hostWdata,
  output logic [DW-1:0]     hostRdata,
  input  logic [IN_W-1:0]   statIn,
  output logic              intN
);
  strobe_t           strobe;
  logic [CH_W-1:0]   chIdx;
  logic [REG_W-1:0]  regIdx;

  assign chIdx  = hostAddr[REG_W +: CH_W];
  assign regIdx = hostAddr[REG_W-1:0];

  statbank_ctrl #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .hostWr    (hostWr),
    .chIdx     (chIdx),
    .regIdx    (regIdx),
    .hostWdata (hostWdata),
    .strobe    (strobe)
  );

  statbank_dp #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .statIn (statIn),
    .rdCh   (chIdx),
    .rdReg  (regIdx),
    .rdData (hostRdata),
    .intN   (intN)
  );
endmodule

// File: tb/status_latch_bank_bench.sv
`timescale 1ns/100ps
module status_latch_bank_bench;
  import statbank_pkg::*;
  localparam int NCH = 2;
  localparam int AW  = 5;
  localparam int SW  = NCH * REG_COUNT * DW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          hostWr = 1'b0;
  logic [AW-1:0] hostAddr = '0;
  logic [7:0]    hostWdata = '0;
  logic [SW-1:0] statIn = '0;
  wire  [7:0]    hostRdata;
  wire           intN;

  logic [8:0] expQ[$];
  string      tagQ[$];
  int         runCnt = 0;
  int         failCnt = 0;
  bit         finished = 1'b0;
  event       sampleEv;

  always #2.5 clk = ~clk;

  status_latch_bank #(.NUM_CH(NCH)) u_status_latch_bank (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .statIn(statIn), .intN(intN)
  );

  function automatic logic [AW-1:0] addrOf(input int ch, input int idx);
    return {ch[0], idx[3:0]};
  endfunction

  // monitor: pops expected items and compares with the outputs
  initial begin
    forever begin
      @(sampleEv);
      while (expQ.size() > 0) begin
        logic [8:0] e;
        string      t;
        logic [7:0] act;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        act = e[8] ? {7'b0, intN} : hostRdata;
        runCnt++;
        if (act != e[7:0]) begin
          failCnt++;
          $display("FAIL %s: actual %h expected %h", t, act, e[7:0]);
        end
      end
    end
  end

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", runCnt, failCnt);
    $finish;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    hostAddr = a; hostWdata = d; hostWr = 1'b1;
    @(negedge clk);
    hostWr = 1'b0;
  endtask

  task automatic chkRd(input logic [AW-1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    hostAddr = a;
    expQ.push_back({1'b0, exp});
    tagQ.push_back(tag);
    #1 ->sampleEv;
  endtask

  task automatic chkInt(input logic exp, input string tag);
    @(negedge clk);
    expQ.push_back({1'b1, 7'b0, exp});
    tagQ.push_back(tag);
    #1 ->sampleEv;
  endtask

  task automatic pulseReg(input int ch, input int idx, input logic [7:0] bits);
    @(negedge clk);
    statIn[(ch*REG_COUNT+idx)*DW +: DW] = bits;
    @(negedge clk);
    statIn[(ch*REG_COUNT+idx)*DW +: DW] = '0;
  endtask

  task automatic setLevel(input int ch, input int idx, input int b, input logic v);
    @(negedge clk);
    statIn[(ch*REG_COUNT+idx)*DW + b] = v;
  endtask

  task automatic wrWithPulse(input int ch, input int idx, input logic [7:0] d, input logic [7:0] bits);
    @(negedge clk);
    hostAddr = addrOf(ch, idx); hostWdata = d; hostWr = 1'b1;
    statIn[(ch*REG_COUNT+idx)*DW +: DW] = bits;
    @(negedge clk);
    hostWr = 1'b0;
    statIn[(ch*REG_COUNT+idx)*DW +: DW] = '0;
  endtask

  task automatic readReg(input int ch, input int idx, input logic [7:0] mask,
                         input logic [7:0] exp, input string tag);
    wr(addrOf(ch, idx), mask);
    chkRd(addrOf(ch, idx), exp, tag);
  endtask

  task automatic clearReg(input int ch, input int idx, input logic [7:0] v);
    wr(addrOf(ch, idx), v);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failCnt++;
      $display("FAIL watchdog (all requirements): actual hung, expected completion");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    chkRd(addrOf(0, 0), 8'h00, "R1 status copy");
    chkRd(addrOf(0, 8), 8'h00, "R1 enable reg");
    chkRd(addrOf(0, 15), 8'h00, "R1 summary");
    chkInt(1'b1, "R1 intN");

    // R2 latch and hold
    pulseReg(0, 0, 8'h80);
    chkInt(1'b1, "R8 disabled bit");
    readReg(0, 0, 8'hFF, 8'h80, "R2 latched after pulse");

    // R3 masked capture, R4 selective clear, R5 no re-set
    pulseReg(0, 0, 8'h40);
    clearReg(0, 0, 8'h80);
    readReg(0, 0, 8'h0F, 8'h80, "R3 unselected bits held");
    clearReg(0, 0, 8'h00);
    readReg(0, 0, 8'hF0, 8'h40, "R3 selected bits refreshed");
    clearReg(0, 0, 8'h40);
    readReg(0, 0, 8'hFF, 8'h00, "R5 event stays clear");
    clearReg(0, 0, 8'h00);

    // R4 only the one-bits of the clear value
    pulseReg(0, 1, 8'h03);
    readReg(0, 1, 8'hFF, 8'h03, "R4 both set");
    clearReg(0, 1, 8'h01);
    readReg(0, 1, 8'hFF, 8'h02, "R4 partial clear");
    clearReg(0, 1, 8'h02);
    readReg(0, 1, 8'hFF, 8'h00, "R4 full clear");
    clearReg(0, 1, 8'h00);

    // R6 level alarm re-asserts
    setLevel(0, 0, 0, 1'b1);
    readReg(0, 0, 8'hFF, 8'h01, "R6 alarm seen");
    clearReg(0, 0, 8'h01);
    readReg(0, 0, 8'hFF, 8'h01, "R6 alarm re-set");
    setLevel(0, 0, 0, 1'b0);
    clearReg(0, 0, 8'h01);
    readReg(0, 0, 8'hFF, 8'h00, "R6 alarm gone");
    clearReg(0, 0, 8'h00);

    // R7 set beats clear
    pulseReg(0, 0, 8'h04);
    readReg(0, 0, 8'hFF, 8'h04, "R7 set");
    wrWithPulse(0, 0, 8'h04, 8'h04);
    readReg(0, 0, 8'hFF, 8'h04, "R7 event kept");
    clearReg(0, 0, 8'h04);
    readReg(0, 0, 8'hFF, 8'h00, "R7 later clear");
    clearReg(0, 0, 8'h00);

    // R8 / R10 enables and interrupt
    wr(addrOf(0, 8), 8'h10);
    chkRd(addrOf(0, 8), 8'h10, "R10 enable readback");
    pulseReg(0, 0, 8'h20);
    chkInt(1'b1, "R8 disabled bit");
    pulseReg(0, 0, 8'h10);
    chkInt(1'b0, "R8 enabled bit");
    chkRd(addrOf(0, 15), 8'h01, "R9 ch0 status");
    readReg(0, 0, 8'hFF, 8'h30, "R8 both latched");
    clearReg(0, 0, 8'h30);
    chkInt(1'b1, "R8 release");
    pulseReg(0, 2, 8'hFF);
    chkInt(1'b1, "R8 info reg no interrupt");
    readReg(0, 2, 8'hFF, 8'hFF, "R8 info latched");
    clearReg(0, 2, 8'hFF);

    // R9 / R11 HDLC on channel 1
    wr(addrOf(1, 10), 8'h01);
    pulseReg(1, 5, 8'h01);
    chkInt(1'b0, "R8 hdlc enabled");
    chkRd(addrOf(0, 15), 8'h08, "R9 ch1 hdlc");
    chkRd(addrOf(1, 15), 8'h08, "R9 any channel");
    readReg(0, 5, 8'hFF, 8'h00, "R11 ch0 untouched");
    clearReg(0, 5, 8'h00);
    readReg(1, 5, 8'hFF, 8'h01, "R11 ch1 latched");
    clearReg(1, 5, 8'h01);
    chkInt(1'b1, "R11 ch1 cleared");
    chkRd(addrOf(1, 15), 8'h00, "R9 idle");

    // R10 ignored writes
    wr(addrOf(0, 15), 8'hFF);
    chkRd(addrOf(0, 15), 8'h00, "R10 summary write ignored");
    wr(addrOf(0, 7), 8'hFF);
    chkRd(addrOf(0, 7), 8'h00, "R10 unused index");
    chkRd(addrOf(0, 8), 8'h10, "R10 enable kept");

    #3;
    finished = 1'b1;
    report();
  end
endmodule